// File: doc/BRIEF.md
# Software Interrupt Pending Register

This block keeps the pending software-interrupt bits of one processor core. Software reaches it through a small register port with four addresses. One address replaces the contents. One sets bits without touching the others. One clears bits without touching the others. The fourth holds the core's 4-bit interrupt priority threshold. Two timer-match units can also set their own bits directly in hardware.

From the pending bits the block works out the highest pending level and compares it with the threshold. The core receives a level-sensitive interrupt request and a one-cycle re-check pulse. The pulse tells the trap logic to look again, and it fires only when the highest pending level rises or when the threshold is rewritten. Every access made without privilege faults and has no effect.

A small two-state notifier drives the re-check pulse. Its states are NTF_IDLE and NTF_PULSE. It moves from NTF_IDLE to NTF_PULSE on a trigger. It stays in NTF_PULSE while triggers keep arriving, and it returns to NTF_IDLE in the first cycle without one.

Top module: `swint_pending`

## Requirements
- R1: After reset the pending bits and the threshold are zero, and `irq_req`, `recheck_pulse`, `acc_fault`, `acc_rdata` and `pend_level` are all zero.
- R2: A privileged write to address 0 replaces all 17 pending bits with `acc_wdata`. A privileged read of address 0, 1 or 2 returns the pending bits on `acc_rdata` in the cycle after the access. A read of address 3 returns the threshold in bits 3..0 and zeros above them.
- R3: A privileged write to address 1 ORs `acc_wdata` into the pending bits.
- R4: A privileged write to address 2 clears each pending bit whose `acc_wdata` bit is one and keeps every other bit.
- R5: A write without privilege (`acc_priv`=0) to any address sets `acc_fault` to 1 in the following cycle and leaves both the pending bits and the threshold unchanged.
- R6: A read without privilege sets `acc_fault` to 1 in the following cycle and returns zero on `acc_rdata`. A privileged access leaves `acc_fault` at 0.
- R7: `pend_level` is the highest pending level. Bits 15..1 stand for levels 15..1. Bit 0 (tick match) and bit 16 (system-tick match) both stand for level 14. With nothing pending the level is 0.
- R8: `irq_req` is high exactly while `pend_level` is strictly greater than the threshold.
- R9: `recheck_pulse` is high in the cycle after an update that raises `pend_level`. An update that lowers the level or leaves it equal gives no pulse.
- R10: A privileged write to address 3 stores `acc_wdata[3:0]` as the threshold and raises `recheck_pulse` in the following cycle.
- R11: `tick_match_set` sets bit 0 and `stick_match_set` sets bit 16. A hardware set wins over a software clear or replace of the same bit in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Register access this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 2 | 0 main, 1 set alias, 2 clear alias, 3 threshold |
| acc_wdata | input | 17 | Write data |
| acc_priv | input | 1 | Access is privileged |
| acc_rdata | output | 17 | Read data, valid the cycle after a read |
| acc_fault | output | 1 | Privilege fault, the cycle after the access |
| tick_match_set | input | 1 | Hardware set of bit 0 |
| stick_match_set | input | 1 | Hardware set of bit 16 |
| pend_level | output | 4 | Highest pending level |
| irq_req | output | 1 | Pending level above threshold |
| recheck_pulse | output | 1 | Re-check request pulse |

## Verification
The bench mixes bit 0 with a mid-range bit, so a design that takes the timer bits at face value would report 8 instead of 14. It also holds the pending level equal to the threshold, where an off-by-one compare would raise a spurious request. It makes updates that lower the level or leave it equal, which catches a design that pulses on every write. It clears and hardware-sets bit 0 in the same cycle, where a wrong ordering would lose a timer interrupt. Unprivileged writes to every alias and to the threshold must leave the state untouched, and an unprivileged read must return zero rather than leak the contents.

// File: rtl/swint_pkg.sv
package swint_pkg;
    localparam int SWI_W    = 17;
    localparam int LVL_W    = 4;
    localparam int TICK_LVL = 14;

    typedef enum logic [1:0] {
        ADDR_MAIN = 2'd0,
        ADDR_SET  = 2'd1,
        ADDR_CLR  = 2'd2,
        ADDR_LVL  = 2'd3
    } swint_addr_e;

    typedef enum logic {
        NTF_IDLE  = 1'b0,
        NTF_PULSE = 1'b1
    } ntf_state_e;
endpackage

// File: rtl/swint_lvl_enc.sv
module swint_lvl_enc #(
    parameter int W   = 17,
    parameter int LW  = 4,
    parameter int TL  = 14
) (
    input  logic [W-1:0]  vec,
    output logic [LW-1:0] lvl
);
    localparam logic [LW-1:0] TIMER_LVL = LW'(TL);

    logic timer_hit;
    assign timer_hit = vec[0] | vec[W-1];

    always_comb begin
        lvl = '0;
        for (int i = 1; i < W-1; i++) begin
            if (vec[i]) lvl = LW'(i);
        end
        if (timer_hit && (lvl < TIMER_LVL)) lvl = TIMER_LVL;
    end
endmodule

// File: rtl/swint_regs.sv
module swint_regs
    import swint_pkg::*;
#(
    parameter int W  = 17,
    parameter int LW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc_valid,
    input  logic          acc_write,
    input  logic [1:0]    acc_addr,
    input  logic [W-1:0]  acc_wdata,
    input  logic          acc_priv,
    input  logic          tick_set,
    input  logic          stick_set,
    output logic [W-1:0]  pend_q,
    output logic [W-1:0]  pend_nxt,
    output logic [LW-1:0] pil_q,
    output logic          pil_wr,
    output logic [W-1:0]  rdata_q,
    output logic          fault_q
);
    localparam int PAD_W = W - LW;

    swint_addr_e  addr;
    logic         ok_wr;
    logic         ok_rd;
    logic         bad;
    logic [W-1:0] sw_val;
    logic [W-1:0] hw_mask;
    logic [W-1:0] rd_val;

    assign addr    = swint_addr_e'(acc_addr);
    assign ok_wr   = acc_valid && acc_write && acc_priv;
    assign ok_rd   = acc_valid && !acc_write && acc_priv;
    assign bad     = acc_valid && !acc_priv;
    assign pil_wr  = ok_wr && (addr == ADDR_LVL);

    always_comb begin
        hw_mask        = '0;
        hw_mask[0]     = tick_set;
        hw_mask[W-1]   = stick_set;
    end

    always_comb begin
        sw_val = pend_q;
        if (ok_wr) begin
            unique case (addr)
                ADDR_MAIN: sw_val = acc_wdata;
                ADDR_SET:  sw_val = pend_q | acc_wdata;
                ADDR_CLR:  sw_val = pend_q & ~acc_wdata;
                ADDR_LVL:  sw_val = pend_q;
            endcase
        end
        pend_nxt = sw_val | hw_mask;
    end

    always_comb begin
        rd_val = '0;
        if (ok_rd) begin
            unique case (addr)
                ADDR_MAIN, ADDR_SET, ADDR_CLR: rd_val = pend_q;
                ADDR_LVL:                      rd_val = {{PAD_W{1'b0}}, pil_q};
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q  <= '0;
            pil_q   <= '0;
            rdata_q <= '0;
            fault_q <= 1'b0;
        end else begin
            pend_q  <= pend_nxt;
            if (pil_wr) pil_q <= acc_wdata[LW-1:0];
            rdata_q <= rd_val;
            fault_q <= bad;
        end
    end
endmodule

// File: rtl/swint_notify.sv
module swint_notify
    import swint_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic trigger,
    output logic pulse
);
    ntf_state_e state_q;
    ntf_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            NTF_IDLE:  if (trigger)  state_d = NTF_PULSE;
            NTF_PULSE: if (!trigger) state_d = NTF_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= NTF_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        pulse = (state_q == NTF_PULSE);
    end
endmodule

// File: rtl/swint_pending.sv
module swint_pending
    import swint_pkg::*;
#(
    parameter int W  = SWI_W,
    parameter int LW = LVL_W,
    parameter int TL = TICK_LVL
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc_valid,
    input  logic          acc_write,
    input  logic [1:0]    acc_addr,
    input  logic [W-1:0]  acc_wdata,
    input  logic          acc_priv,
    output logic [W-1:0]  acc_rdata,
    output logic          acc_fault,
    input  logic          tick_match_set,
    input  logic          stick_match_set,
    output logic [LW-1:0] pend_level,
    output logic          irq_req,
    output logic          recheck_pulse
);
    logic [W-1:0]  pend_bits;
    logic [W-1:0]  pend_next;
    logic [LW-1:0] pil_bits;
    logic          pil_write;
    logic [LW-1:0] lvl_now;
    logic [LW-1:0] lvl_next;
    logic          rise;

    swint_regs #(.W(W), .LW(LW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc_valid(acc_valid),
        .acc_write(acc_write),
        .acc_addr (acc_addr),
        .acc_wdata(acc_wdata),
        .acc_priv (acc_priv),
        .tick_set (tick_match_set),
        .stick_set(stick_match_set),
        .pend_q   (pend_bits),
        .pend_nxt (pend_next),
        .pil_q    (pil_bits),
        .pil_wr   (pil_write),
        .rdata_q  (acc_rdata),
        .fault_q  (acc_fault)
    );

    swint_lvl_enc #(.W(W), .LW(LW), .TL(TL)) u_enc_now (
        .vec(pend_bits),
        .lvl(lvl_now)
    );

    swint_lvl_enc #(.W(W), .LW(LW), .TL(TL)) u_enc_next (
        .vec(pend_next),
        .lvl(lvl_next)
    );

    assign rise = (lvl_next > lvl_now) || pil_write;

    swint_notify u_ntf (
        .clk    (clk),
        .rst_n  (rst_n),
        .trigger(rise),
        .pulse  (recheck_pulse)
    );

    assign pend_level = lvl_now;
    assign irq_req    = (lvl_now > pil_bits);
endmodule

// File: rtl/swint_checker.sv
module swint_checker #(
    parameter int W  = 17,
    parameter int LW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          acc_valid,
    input logic          acc_write,
    input logic [1:0]    acc_addr,
    input logic [W-1:0]  acc_wdata,
    input logic          acc_priv,
    input logic [W-1:0]  acc_rdata,
    input logic          acc_fault,
    input logic          tick_match_set,
    input logic          stick_match_set,
    input logic [LW-1:0] pend_level,
    input logic          recheck_pulse,
    input logic [W-1:0]  pend_q,
    input logic [LW-1:0] pil_q
);
    assert_nonpriv_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_priv && !tick_match_set && !stick_match_set)
        |=> ($stable(pend_q) && $stable(pil_q)));

    assert_fault_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_priv) |=> acc_fault);

    assert_no_fault_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_priv) |=> !acc_fault);

    assert_zero_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_priv && !acc_write) |=> (acc_rdata == '0));

    assert_set_alias_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_priv && acc_write && acc_addr == 2'd1)
        |=> ((pend_q & $past(acc_wdata)) == $past(acc_wdata)));

    assert_pil_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_priv && acc_write && acc_addr == 2'd3) |=> recheck_pulse);

    assert_tick_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        tick_match_set |=> pend_q[0]);

    assert_stick_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        stick_match_set |=> pend_q[W-1]);

    assert_idle_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q == '0) |-> (pend_level == '0));
endmodule

bind swint_pending swint_checker #(.W(W), .LW(LW)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .acc_valid      (acc_valid),
    .acc_write      (acc_write),
    .acc_addr       (acc_addr),
    .acc_wdata      (acc_wdata),
    .acc_priv       (acc_priv),
    .acc_rdata      (acc_rdata),
    .acc_fault      (acc_fault),
    .tick_match_set (tick_match_set),
    .stick_match_set(stick_match_set),
    .pend_level     (pend_level),
    .recheck_pulse  (recheck_pulse),
    .pend_q         (pend_bits),
    .pil_q          (pil_bits)
);

// File: tb/tb_swint_pending.sv
module tb_swint_pending;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [1:0]  acc_addr = 2'd0;
    logic [16:0] acc_wdata = '0;
    logic        acc_priv = 1'b0;
    logic [16:0] acc_rdata;
    logic        acc_fault;
    logic        tick_match_set = 1'b0;
    logic        stick_match_set = 1'b0;
    logic [3:0]  pend_level;
    logic        irq_req;
    logic        recheck_pulse;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    swint_pending dut (
        .clk(clk), .rst_n(rst_n),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_addr(acc_addr),
        .acc_wdata(acc_wdata), .acc_priv(acc_priv),
        .acc_rdata(acc_rdata), .acc_fault(acc_fault),
        .tick_match_set(tick_match_set), .stick_match_set(stick_match_set),
        .pend_level(pend_level), .irq_req(irq_req), .recheck_pulse(recheck_pulse)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // One clock of stimulus; outputs are sampled 1 ns after the edge.
    task automatic cyc(input bit v, input bit wr, input logic [1:0] a,
                       input logic [16:0] d, input bit pr, input bit tk, input bit stk);
        @(negedge clk);
        acc_valid = v; acc_write = wr; acc_addr = a; acc_wdata = d;
        acc_priv = pr; tick_match_set = tk; stick_match_set = stk;
        @(posedge clk);
        #1;
        acc_valid = 0; acc_write = 0; tick_match_set = 0; stick_match_set = 0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [16:0] d);
        cyc(1, 1, a, d, 1, 0, 0);
    endtask

    task automatic rd_chk(input string req, input logic [1:0] a, input logic [16:0] exp);
        cyc(1, 0, a, '0, 1, 0, 0);
        chk(req, 32'(acc_rdata), 32'(exp));
    endtask

    task automatic t_reset();
        chk("R1 pending", 32'(pend_level), 0);
        chk("R1 irq", 32'(irq_req), 0);
        chk("R1 recheck", 32'(recheck_pulse), 0);
        chk("R1 fault", 32'(acc_fault), 0);
        chk("R1 rdata", 32'(acc_rdata), 0);
        rd_chk("R1 contents", 2'd0, 17'h0);
        rd_chk("R1 threshold", 2'd3, 17'h0);
    endtask

    task automatic t_main_write();
        wr(2'd0, 17'h0A5A5);
        rd_chk("R2 main write", 2'd0, 17'h0A5A5);
        wr(2'd0, 17'h10003);
        rd_chk("R2 replace", 2'd1, 17'h10003);
    endtask

    task automatic t_set_alias();
        wr(2'd0, 17'h00110);
        wr(2'd1, 17'h01010);
        rd_chk("R3 set alias", 2'd0, 17'h01110);
    endtask

    task automatic t_clear_alias();
        wr(2'd0, 17'h1F00F);
        wr(2'd2, 17'h10105);
        rd_chk("R4 clear alias", 2'd2, 17'h0F00A);
    endtask

    task automatic t_nonpriv_write();
        wr(2'd0, 17'h00400);
        wr(2'd3, 17'h00007);
        cyc(1, 1, 2'd0, 17'h1FFFF, 0, 0, 0);
        chk("R5 fault main", 32'(acc_fault), 1);
        cyc(1, 1, 2'd1, 17'h00001, 0, 0, 0);
        chk("R5 fault set", 32'(acc_fault), 1);
        cyc(1, 1, 2'd2, 17'h00400, 0, 0, 0);
        cyc(1, 1, 2'd3, 17'h00002, 0, 0, 0);
        chk("R5 fault level", 32'(acc_fault), 1);
        rd_chk("R5 contents kept", 2'd0, 17'h00400);
        chk("R6 no fault priv", 32'(acc_fault), 0);
        rd_chk("R5 threshold kept", 2'd3, 17'h00007);
    endtask

    task automatic t_nonpriv_read();
        wr(2'd0, 17'h12345);
        cyc(1, 0, 2'd0, '0, 0, 0, 0);
        chk("R6 read fault", 32'(acc_fault), 1);
        chk("R6 read zero", 32'(acc_rdata), 0);
    endtask

    task automatic t_levels();
        wr(2'd0, 17'h00001); chk("R7 bit0 level", 32'(pend_level), 14);
        wr(2'd0, 17'h10000); chk("R7 bit16 level", 32'(pend_level), 14);
        wr(2'd0, 17'h08000); chk("R7 bit15 level", 32'(pend_level), 15);
        wr(2'd0, 17'h18000); chk("R7 bit15 over timer", 32'(pend_level), 15);
        wr(2'd0, 17'h00002); chk("R7 level1", 32'(pend_level), 1);
        wr(2'd0, 17'h00101); chk("R7 timer over 8", 32'(pend_level), 14);
        wr(2'd0, 17'h00000); chk("R7 empty", 32'(pend_level), 0);
    endtask

    task automatic t_irq();
        wr(2'd3, 17'h5);
        wr(2'd0, 17'h00020);
        chk("R8 equal no irq", 32'(irq_req), 0);
        wr(2'd1, 17'h00040);
        chk("R8 above irq", 32'(irq_req), 1);
        wr(2'd3, 17'h6);
        chk("R8 raised threshold", 32'(irq_req), 0);
        wr(2'd3, 17'hF);
        wr(2'd0, 17'h08000);
        chk("R8 level15 vs 15", 32'(irq_req), 0);
        wr(2'd3, 17'h0);
        chk("R8 threshold0", 32'(irq_req), 1);
    endtask

    task automatic t_recheck();
        wr(2'd0, 17'h0);
        wr(2'd0, 17'h00002); chk("R9 rise 0->1", 32'(recheck_pulse), 1);
        cyc(0, 0, 2'd0, '0, 1, 0, 0);
        chk("R9 pulse ends", 32'(recheck_pulse), 0);
        wr(2'd0, 17'h00006); chk("R9 rise 1->2", 32'(recheck_pulse), 1);
        wr(2'd2, 17'h00004); chk("R9 fall no pulse", 32'(recheck_pulse), 0);
        wr(2'd1, 17'h00002); chk("R9 equal no pulse", 32'(recheck_pulse), 0);
        wr(2'd1, 17'h00001); chk("R9 rise to 14", 32'(recheck_pulse), 1);
        cyc(0, 0, 2'd0, '0, 1, 1, 0);
        chk("R9 hw set same level", 32'(recheck_pulse), 0);
    endtask

    task automatic t_pil_write();
        wr(2'd0, 17'h0);
        cyc(0, 0, 2'd0, '0, 1, 0, 0);
        wr(2'd3, 17'h1FFF9);
        chk("R10 pulse", 32'(recheck_pulse), 1);
        rd_chk("R10 stored", 2'd3, 17'h00009);
    endtask

    task automatic t_hw_race();
        wr(2'd0, 17'h00001);
        cyc(1, 1, 2'd2, 17'h00001, 1, 1, 0);
        rd_chk("R11 tick beats clear", 2'd0, 17'h00001);
        wr(2'd0, 17'h0);
        cyc(0, 0, 2'd0, '0, 1, 0, 1);
        rd_chk("R11 stick set", 2'd0, 17'h10000);
        cyc(1, 1, 2'd0, 17'h00000, 1, 0, 1);
        rd_chk("R11 stick beats replace", 2'd0, 17'h10000);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_main_write();
        t_set_alias();
        t_clear_alias();
        t_nonpriv_write();
        t_nonpriv_read();
        t_levels();
        t_irq();
        t_recheck();
        t_pil_write();
        t_hw_race();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule